// File: doc/BRIEF.md
# Polyphase Interpolating Pulse-Shaping Filter

This block raises the rate of a stream of signed 16-bit symbols by a factor of sixteen and shapes them with a low-pass FIR response, as needed in front of a transmitter's converter. The prototype response is split into sixteen short branches of seven taps. For each output instant exactly one branch is evaluated against the seven most recent symbols, so the zeros that plain zero-stuffing would insert are never multiplied.

A single sequential multiply-accumulate unit walks the branch coefficients in ascending memory order. After the sixteenth branch the block raises its input ready flag and waits for the next symbol. The accumulated sum is scaled down and clipped to the 16-bit output range. Outputs are one-cycle pulses on `out_valid`; the output has no back-pressure.

Top module: `polyfir_interp`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `out_data` is 0 and every delay-line stage holds zero, so the first outputs depend on the first accepted symbol alone.
- R2: Every accepted symbol produces exactly 16 output pulses, for phases p = 0 to 15 in that order, before the next symbol can be taken.
- R3: The output for symbol index m and phase p is y = sat(floor(S / 2^17)), where S = sum over j = 0..6 of h[16j+p] * x[m-j]. Here x[k] is the k-th accepted symbol, and x is 0 for negative k.
- R4: `COEF_FLAT` holds 112 signed 16-bit words; the word at bits [16k +: 16] with k = 7p + j is h[16j+p], so the branch pointer reads addresses in ascending order. The default is h[n] = 512 * min(n+1, 112-n).
- R5: Scaling is an arithmetic right shift of the 40-bit accumulator by 17, which rounds toward minus infinity for negative sums.
- R6: The scaled result is saturated to the range -32768 to 32767.
- R7: `in_ready` is 1 only while the block waits for a symbol, meaning after reset or once the 16th output of the previous symbol has been issued. A symbol presented while `in_ready` is 0 is not taken and does not reach any output.
- R8: With a symbol accepted on clock edge A, phase p is output with `out_valid` high for exactly one cycle following edge A + 8(p+1). This is seven MAC cycles plus one write cycle per output.
- R9: While the block waits and `in_valid` is 0, no output is produced and the delay line and phase are held; the sequence resumes correctly when a symbol arrives.
- R10: `out_data` changes only together with an `out_valid` pulse and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Symbol present on `in_data` |
| in_ready | output | 1 | Block will take a symbol on this edge |
| in_data | input | 16 | Signed input symbol |
| out_valid | output | 1 | One-cycle pulse marking a new output sample |
| out_data | output | 16 | Signed, scaled and saturated output sample |

## Verification
The bench first sends a positive impulse and then a negative impulse, which read the coefficient layout out of the outputs. A wrong branch order or a reversed pointer would permute the response, and a truncating shift would move every negative sample by one toward zero. A second instance with full-scale coefficients takes long runs of extreme symbols, so an accumulator that wraps or a missing clip would produce sign-flipped samples. Garbage is driven with `in_valid` high whenever `in_ready` is low, and `in_valid` is dropped at some waits. A design that takes symbols early or advances phase during a stall would emit corrupted or mistimed pulses.

// File: rtl/polyfir_pkg.sv
package polyfir_pkg;

  localparam int DEF_PHASES = 16;
  localparam int DEF_TAPS   = 7;
  localparam int DEF_CW     = 16;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_MAC  = 2'd1,
    ST_EMIT = 2'd2
  } fsm_e;

  // Triangular default response, stored branch-major: word (p*TAPS + j) = h[j*PHASES + p]
  function automatic logic [DEF_PHASES*DEF_TAPS*DEF_CW-1:0] default_coefs();
    logic [DEF_PHASES*DEF_TAPS*DEF_CW-1:0] flat;
    flat = '0;
    for (int p = 0; p < DEF_PHASES; p++) begin
      for (int j = 0; j < DEF_TAPS; j++) begin
        int n;
        int v;
        n = j * DEF_PHASES + p;
        v = ((n + 1) < (DEF_PHASES * DEF_TAPS - n)) ? (n + 1) : (DEF_PHASES * DEF_TAPS - n);
        v = v * 512;
        flat[(p * DEF_TAPS + j) * DEF_CW +: DEF_CW] = DEF_CW'(v);
      end
    end
    return flat;
  endfunction

endpackage

// File: rtl/polyfir_rst_sync.sv
module polyfir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/polyfir_coef_rom.sv
module polyfir_coef_rom #(
  parameter int PHASES = 16,
  parameter int TAPS   = 7,
  parameter int CW     = 16,
  parameter logic [PHASES*TAPS*CW-1:0] COEF_FLAT = '0,
  localparam int NCOEF  = PHASES * TAPS,
  localparam int ADDR_W = $clog2(NCOEF)
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic signed [CW-1:0] coef
);
  logic signed [CW-1:0] rom [NCOEF];

  for (genvar g = 0; g < NCOEF; g++) begin : g_word
    assign rom[g] = COEF_FLAT[g*CW +: CW];
  end

  always_comb begin
    coef = '0;
    for (int i = 0; i < NCOEF; i++) begin
      if (addr == ADDR_W'(i)) coef = rom[i];
    end
  end
endmodule

// File: rtl/polyfir_delay_line.sv
module polyfir_delay_line #(
  parameter int DEPTH = 7,
  parameter int DW    = 16,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  input  logic [SEL_W-1:0]     sel,
  output logic signed [DW-1:0] dout
);
  logic signed [DW-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic signed [DW-1:0] stage_d;
    if (i == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_body
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[i] <= '0;
      else if (shift_en) stage_q[i] <= stage_d;
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel == SEL_W'(i)) dout = stage_q[i];
    end
  end
endmodule

// File: rtl/polyfir_mac.sv
module polyfir_mac #(
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int ACCW      = 40,
  parameter int OUT_SHIFT = 17,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] sample,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] result
);
  localparam logic signed [ACCW-1:0] SAT_HI = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SAT_LO = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_d;
  logic signed [ACCW-1:0] scaled;
  logic                   acc_en;

  assign prod     = sample * coef;
  assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign acc_en   = clr | en;

  always_comb begin
    if (clr) acc_d = '0;
    else     acc_d = acc_q + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign scaled = acc_q >>> OUT_SHIFT;

  always_comb begin
    if (scaled > SAT_HI)      result = SAT_HI[DW-1:0];
    else if (scaled < SAT_LO) result = SAT_LO[DW-1:0];
    else                      result = scaled[DW-1:0];
  end
endmodule

// File: rtl/polyfir_interp.sv
module polyfir_interp #(
  parameter int PHASES    = 16,
  parameter int TAPS      = 7,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int ACCW      = 40,
  parameter int OUT_SHIFT = 17,
  parameter logic [PHASES*TAPS*CW-1:0] COEF_FLAT = polyfir_pkg::default_coefs()
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  import polyfir_pkg::*;

  localparam int NCOEF  = PHASES * TAPS;
  localparam int ADDR_W = $clog2(NCOEF);
  localparam int PH_W   = $clog2(PHASES);
  localparam int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic rst_sn;

  fsm_e              state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic              phase_en, tap_en;
  logic              accept, mac_en, acc_clr, emit;
  logic [ADDR_W-1:0] rom_addr;
  logic signed [CW-1:0] coef;
  logic signed [DW-1:0] tap_sample;
  logic signed [DW-1:0] mac_result;
  logic                 out_valid_q;
  logic signed [DW-1:0] out_data_q;

  polyfir_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  // Sequencer next-state logic
  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    tap_d    = tap_q;
    phase_en = 1'b0;
    tap_en   = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (in_valid) begin
          state_d = ST_MAC;
          tap_d   = '0;
          tap_en  = 1'b1;
        end
      end
      ST_MAC: begin
        tap_en = 1'b1;
        if (tap_q == TAP_W'(TAPS - 1)) begin
          tap_d   = '0;
          state_d = ST_EMIT;
        end else begin
          tap_d = tap_q + 1'b1;
        end
      end
      ST_EMIT: begin
        phase_en = 1'b1;
        if (phase_q == PH_W'(PHASES - 1)) begin
          phase_d = '0;
          state_d = ST_WAIT;
        end else begin
          phase_d = phase_q + 1'b1;
          state_d = ST_MAC;
        end
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_WAIT;
      phase_q <= '0;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      if (phase_en) phase_q <= phase_d;
      if (tap_en)   tap_q   <= tap_d;
    end
  end

  assign in_ready = (state_q == ST_WAIT);
  assign accept   = in_ready & in_valid;
  assign mac_en   = (state_q == ST_MAC);
  assign emit     = (state_q == ST_EMIT);
  assign acc_clr  = ~mac_en;
  assign rom_addr = ADDR_W'(phase_q) * ADDR_W'(TAPS) + ADDR_W'(tap_q);

  polyfir_coef_rom #(
    .PHASES    (PHASES),
    .TAPS      (TAPS),
    .CW        (CW),
    .COEF_FLAT (COEF_FLAT)
  ) u_rom (
    .addr (rom_addr),
    .coef (coef)
  );

  polyfir_delay_line #(
    .DEPTH (TAPS),
    .DW    (DW)
  ) u_dly (
    .clk      (clk),
    .rst_n    (rst_sn),
    .shift_en (accept),
    .din      (in_data),
    .sel      (tap_q),
    .dout     (tap_sample)
  );

  polyfir_mac #(
    .DW        (DW),
    .CW        (CW),
    .ACCW      (ACCW),
    .OUT_SHIFT (OUT_SHIFT)
  ) u_mac (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clr    (acc_clr),
    .en     (mac_en),
    .sample (tap_sample),
    .coef   (coef),
    .result (mac_result)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= emit;
      if (emit) out_data_q <= mac_result;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/polyfir_interp_chk.sv
module polyfir_interp_chk #(
  parameter int PHASES = 16,
  parameter int DW     = 16,
  localparam int CNT_W = $clog2(PHASES + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data
);
  logic [CNT_W-1:0] burst_cnt;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_cnt <= '0;
      seen      <= 1'b0;
    end else if (in_valid && in_ready) begin
      burst_cnt <= '0;
      seen      <= 1'b1;
    end else if (out_valid) begin
      burst_cnt <= burst_cnt + 1'b1;
    end
  end

  // R8: output strobe never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: the block is busy right after taking a symbol
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2: no more than PHASES outputs per accepted symbol, none before the first
  a_r2_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen && (burst_cnt < CNT_W'(PHASES))));

  // R7: ready only once the full burst has been issued
  a_r7_ready_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!seen || ((burst_cnt + CNT_W'(out_valid)) == CNT_W'(PHASES))));

  // R10: data moves only with a strobe
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);
endmodule

bind polyfir_interp polyfir_interp_chk #(.PHASES(PHASES), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_polyfir_interp.sv
`timescale 1ns/1ps
module sim_polyfir_interp;
  localparam int NS      = 48;
  localparam int PH      = 16;
  localparam int NT      = 7;
  localparam int WD_CYC  = 30000;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic signed [15:0] in_data;
  logic rdy0, rdy1, ov0, ov1;
  logic signed [15:0] od0, od1;

  int checks;
  int failures;
  int cyc;
  bit finished;

  int sym [NS];

  polyfir_interp u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_data(in_data), .out_valid(ov0), .out_data(od0)
  );

  polyfir_interp #(.COEF_FLAT({112{16'h7FFF}})) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_data(in_data), .out_valid(ov1), .out_data(od1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint h_def(int n);
    int a;
    a = ((n + 1) < (112 - n)) ? (n + 1) : (112 - n);
    return longint'(a * 512);
  endfunction

  function automatic int expect_out(int m, int p, bit full);
    longint s;
    longint y;
    s = 0;
    for (int j = 0; j < NT; j++) begin
      if (m - j >= 0) s += (full ? 64'sd32767 : h_def(16 * j + p)) * longint'(sym[m - j]);
    end
    y = s >>> 17;
    if (y > 32767)  y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  initial begin
    #(WD_CYC * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int idx, k, m_cur, acc_edge, stall, total;
    int last0, last1, lfsr;
    bit started, done, exp_ov, exp_rdy;
    string tag;

    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;

    // stimulus: +impulse, -impulse, pseudo-random, +full-scale run, -full-scale run
    lfsr = 32'h1ACE;
    for (int i = 0; i < NS; i++) begin
      if (i == 0)       sym[i] = 32767;
      else if (i == 8)  sym[i] = -32767;
      else if (i < 16)  sym[i] = 0;
      else if (i < 28) begin
        lfsr = lfsr * 1103515245 + 12345;
        sym[i] = int'($signed(lfsr[23:8]));
      end
      else if (i < 38)  sym[i] = 32767;
      else              sym[i] = -32768;
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rdy0 == 1'b1, "R1 ready", int'(rdy0), 1);
    check(ov0 == 1'b0, "R1 valid", int'(ov0), 0);
    check(od0 == 16'sd0, "R1 data", int'(od0), 0);
    check(ov1 == 1'b0 && od1 == 16'sd0, "R1 second instance", int'(od1), 0);
    repeat (4) @(negedge clk);

    idx = 0; k = 0; m_cur = 0; acc_edge = 0; stall = 0; total = 0;
    last0 = 0; last1 = 0; started = 0; done = 0;

    while (!done) begin
      @(negedge clk);
      // monitor
      exp_ov = started && (k < PH) && (cyc == acc_edge + 8 * (k + 1));
      check(ov0 == exp_ov, "R8,R9 strobe timing", int'(ov0), int'(exp_ov));
      check(ov1 == ov0, "R8 instances agree", int'(ov1), int'(ov0));
      if (ov0) begin
        if (exp_ov) begin
          if (m_cur < 8)       tag = "R4 impulse response";
          else if (m_cur < 16) tag = "R5 negative floor";
          else                 tag = "R3 branch sum";
          check(int'(od0) == expect_out(m_cur, k, 1'b0), tag, int'(od0), expect_out(m_cur, k, 1'b0));
          check(int'(od1) == expect_out(m_cur, k, 1'b1), "R6 saturation", int'(od1), expect_out(m_cur, k, 1'b1));
        end
        k++;
        total++;
        last0 = int'(od0);
        last1 = int'(od1);
      end else begin
        check(int'(od0) == last0, "R10 hold", int'(od0), last0);
        check(int'(od1) == last1, "R10 hold", int'(od1), last1);
      end
      exp_rdy = !started || (k == PH);
      check(rdy0 == exp_rdy, "R7 ready", int'(rdy0), int'(exp_rdy));
      check(rdy1 == rdy0, "R7 ready instances", int'(rdy1), int'(rdy0));
      if (started && k == PH && idx == NS) done = 1;

      // driver
      if (!done) begin
        if (rdy0 && idx < NS) begin
          if (stall > 0) begin
            in_valid = 1'b0;
            in_data  = 16'sh7A5A;
            stall--;
          end else begin
            in_valid = 1'b1;
            in_data  = 16'(sym[idx]);
            acc_edge = cyc + 1;
            k = 0;
            started = 1;
            m_cur = idx;
            idx++;
            if (idx % 4 == 2) stall = 3;
          end
        end else begin
          in_valid = 1'b1;
          in_data  = 16'(32'h5A3C ^ cyc);
        end
      end else begin
        in_valid = 1'b0;
      end
    end

    // R2: sixteen outputs per symbol overall
    check(total == PH * NS, "R2 output count", total, PH * NS);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule